// File: doc/BRIEF.md
# RTC Seconds Prescaler with Digital Rate Trim

This block turns a slow oscillator tick enable (nominally 32768 per second) into a one-second pulse for a real-time clock. A down counter is loaded with the number of oscillator ticks that make up the coming second. It emits a seconds pulse when the final tick of that second arrives.

To correct a crystal that runs fast or slow, one second in every compensation interval (20 seconds by default) is lengthened or shortened by a signed count that software loads. One count per 20-second interval is worth roughly 1.5 ppm of rate. A slow 32767.7 Hz oscillator, for example, is brought back to 32768 Hz by an offset of +6. A second output pulse marks the end of each compensation interval.

The block runs in the system clock domain. Oscillator ticks arrive as single-cycle enables. A synchronous clear restarts both the second and the interval.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset, `sec_o` and `comp_o` are low, and the first second lasts exactly DIV ticks of `osc_tick_i`.
- R2: Only clock cycles with `osc_tick_i` high advance the prescaler. When the offset does not apply, each second lasts DIV ticks.
- R3: `sec_o` is high for one clock cycle. That cycle follows the clock edge at which the final tick of a second is sampled, and `sec_o` is never high in a cycle that does not follow a sampled tick.
- R4: Seconds are numbered 0 to INTERVAL-1 within a compensation interval. Second INTERVAL-1 is the compensated second, and `comp_o` pulses in the same cycle as its `sec_o` pulse and at no other time.
- R5: When `ofs_en_i` is high, the compensated second lasts DIV minus `ofs_i` ticks, with `ofs_i` read as OFS_W-bit two's complement. A positive offset shortens that second and a negative offset lengthens it.
- R6: When DIV minus the offset is below 1, the compensated second lasts exactly 1 tick.
- R7: When `ofs_en_i` is low, `ofs_i` has no effect and every second lasts DIV ticks. `comp_o` still marks each interval end.
- R8: `ofs_i` and `ofs_en_i` are sampled at the tick that ends second INTERVAL-2. A change made earlier in the interval applies to that interval's compensated second. A change made during the compensated second waits for the next interval.
- R9: `clr_i` is synchronous and takes priority over a tick in the same cycle. It clears both pulses in the next cycle and restarts counting at second 0 with a full DIV-tick second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous restart of second and interval |
| osc_tick_i | input | 1 | Single-cycle oscillator tick enable |
| ofs_en_i | input | 1 | Enables the rate offset |
| ofs_i | input | OFS_W | Signed offset in ticks, applied once per interval |
| sec_o | output | 1 | One-second pulse |
| comp_o | output | 1 | Compensation interval end pulse |

## Verification
The bench builds the block with DIV=16, INTERVAL=4 and OFS_W=8. With these values a whole interval lasts only tens of ticks. The full offset range then reaches both extremes: +127 drives the reload far below 1 and exercises the clamp, and -128 stretches a second to 144 ticks. Both extremes, and the exact-1 boundary at +15, fit within a short run. The small interval also lets the bench place offset writes before and after the sampling point and check both halves of R8. It also lands a clear in the middle of an interval, together with a tick.

// File: rtl/rtc_psc_pkg.sv
package rtc_psc_pkg;

  // Length in ticks of the compensated second, never below one tick.
  function automatic int adj_len(int div, int ofs);
    int v;
    v = div - ofs;
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/rtc_reload_sel.sv
module rtc_reload_sel
  import rtc_psc_pkg::*;
#(
  parameter int unsigned DIV   = 32768,
  parameter int unsigned OFS_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             adj_i,
  input  logic             ofs_en_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [CNT_W-1:0] reload_o
);

  int adj;

  always_comb begin
    adj = adj_len(int'(DIV), int'($signed(ofs_i)));
    if (adj_i && ofs_en_i) reload_o = CNT_W'(adj);
    else                   reload_o = CNT_W'(DIV);
  end

endmodule

// File: rtl/rtc_div_cnt.sv
module rtc_div_cnt #(
  parameter int unsigned DIV   = 32768,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // cnt_q holds the ticks still needed to finish the current second
  assign expire_o = tick_i && !clr_i && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_W'(DIV);
    else if (clr_i)    cnt_q <= CNT_W'(DIV);
    else if (expire_o) cnt_q <= reload_i;
    else if (tick_i)   cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/rtc_ivl_cnt.sv
module rtc_ivl_cnt #(
  parameter int unsigned INTERVAL = 20,
  parameter int unsigned IVL_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic             last_o,
  output logic             pre_last_o,
  output logic [IVL_W-1:0] ivl_o
);

  logic [IVL_W-1:0] ivl_q;

  assign last_o     = (ivl_q == IVL_W'(INTERVAL - 1));
  assign pre_last_o = (ivl_q == IVL_W'(INTERVAL - 2));
  assign ivl_o      = ivl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ivl_q <= '0;
    else if (clr_i)  ivl_q <= '0;
    else if (step_i) ivl_q <= last_o ? '0 : ivl_q + IVL_W'(1);
  end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV      = 32768,
  parameter int unsigned INTERVAL = 20,
  parameter int unsigned OFS_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             osc_tick_i,
  input  logic             ofs_en_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             sec_o,
  output logic             comp_o
);

  localparam int unsigned CNT_W = $clog2(DIV + 2**(OFS_W-1) + 1);
  localparam int unsigned IVL_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic             expire;
  logic             last_sec;
  logic             pre_last;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt_q;
  logic [IVL_W-1:0] ivl_q;
  logic             sec_q;
  logic             comp_q;

  // The next second is the compensated one when ending second INTERVAL-2.
  rtc_reload_sel #(.DIV(DIV), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_reload (
    .adj_i    (pre_last),
    .ofs_en_i (ofs_en_i),
    .ofs_i    (ofs_i),
    .reload_o (reload)
  );

  rtc_div_cnt #(.DIV(DIV), .CNT_W(CNT_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .tick_i   (osc_tick_i),
    .reload_i (reload),
    .expire_o (expire),
    .cnt_o    (cnt_q)
  );

  rtc_ivl_cnt #(.INTERVAL(INTERVAL), .IVL_W(IVL_W)) u_ivl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .step_i     (expire),
    .last_o     (last_sec),
    .pre_last_o (pre_last),
    .ivl_o      (ivl_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 1'b0;
      comp_q <= 1'b0;
    end else begin
      sec_q  <= expire;
      comp_q <= expire && last_sec;
    end
  end

  assign sec_o  = sec_q;
  assign comp_o = comp_q;

endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk #(
  parameter int unsigned DIV      = 32768,
  parameter int unsigned INTERVAL = 20,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned IVL_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             osc_tick_i,
  input logic             ofs_en_i,
  input logic             sec_o,
  input logic             comp_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [IVL_W-1:0] ivl_i
);

  a_r4_comp_with_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_o |-> sec_o);

  a_r3_sec_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |-> $past(osc_tick_i));

  a_r9_clr_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (!sec_o && !comp_o));

  a_r7_nominal_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o && !$past(ofs_en_i)) |-> (cnt_i == CNT_W'(DIV)));

  a_r6_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i != '0);

  a_r4_ivl_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ivl_i <= IVL_W'(INTERVAL - 1));

endmodule

bind rtc_prescaler rtc_prescaler_chk #(
  .DIV(DIV), .INTERVAL(INTERVAL), .CNT_W(CNT_W), .IVL_W(IVL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .osc_tick_i (osc_tick_i),
  .ofs_en_i   (ofs_en_i),
  .sec_o      (sec_o),
  .comp_o     (comp_o),
  .cnt_i      (cnt_q),
  .ivl_i      (ivl_q)
);

// File: tb/rtc_prescaler_bench.sv
module rtc_prescaler_bench;

  localparam int DIV      = 16;
  localparam int INTERVAL = 4;
  localparam int OFS_W    = 8;

  localparam int N_VEC = 6;
  localparam logic [7:0] V_OFS [N_VEC] = '{8'd3, 8'hFB, 8'd5, 8'd127, 8'h80, 8'd15};
  localparam logic       V_EN  [N_VEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam int         V_LEN [N_VEC] = '{13, 21, 16, 1, 144, 1};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clr_i = 1'b0;
  logic             osc_tick_i = 1'b0;
  logic             ofs_en_i = 1'b0;
  logic [OFS_W-1:0] ofs_i = '0;
  logic             sec_o;
  logic             comp_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rtc_prescaler #(.DIV(DIV), .INTERVAL(INTERVAL), .OFS_W(OFS_W)) u_rtc_prescaler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .osc_tick_i (osc_tick_i),
    .ofs_en_i   (ofs_en_i),
    .ofs_i      (ofs_i),
    .sec_o      (sec_o),
    .comp_o     (comp_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick(output bit s, output bit c);
    @(negedge clk_i) osc_tick_i = 1'b1;
    @(negedge clk_i) osc_tick_i = 1'b0;
    s = sec_o;
    c = comp_o;
  endtask

  task automatic run_sec(output int len, output bit c);
    bit s;
    bit cc;
    len = 0;
    s   = 1'b0;
    cc  = 1'b0;
    while (!s && len < 1000) begin
      do_tick(s, cc);
      len++;
    end
    c = cc;
  endtask

  // Runs one interval; encodes length*2+comp for compact reporting.
  task automatic check_ivl(input int exp_last, input string req);
    int len;
    bit c;
    for (int s = 0; s < INTERVAL; s++) begin
      int exp_len;
      bit exp_c;
      exp_len = (s == INTERVAL - 1) ? exp_last : DIV;
      exp_c   = (s == INTERVAL - 1);
      run_sec(len, c);
      check(len == exp_len && c == exp_c, req, len * 2 + int'(c), exp_len * 2 + int'(exp_c));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int len;
    bit c;
    repeat (3) @(negedge clk_i);
    check(sec_o == 1'b0 && comp_o == 1'b0, "R1 reset outputs", int'({sec_o, comp_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 first second, R3 pulse width
    run_sec(len, c);
    check(len == DIV && !c, "R1 first second", len, DIV);
    @(negedge clk_i);
    check(sec_o == 1'b0, "R3 single cycle pulse", int'(sec_o), 0);
    for (int s = 1; s < INTERVAL; s++) begin
      run_sec(len, c);
      check(len == DIV && c == (s == INTERVAL - 1), "R7 disabled offset interval", len, DIV);
    end

    // R5 R6 R7 table walk, one interval per vector
    for (int v = 0; v < N_VEC; v++) begin
      ofs_i    = V_OFS[v];
      ofs_en_i = V_EN[v];
      check_ivl(V_LEN[v], "R5/R6/R7 vector");
    end

    // R8: write before the sampling tick applies in this interval
    ofs_en_i = 1'b1;
    ofs_i    = 8'd2;
    run_sec(len, c);
    ofs_i = 8'd5;
    for (int s = 1; s < INTERVAL; s++) begin
      run_sec(len, c);
      if (s == INTERVAL - 1) check(len == DIV - 5 && c, "R8 early write", len, DIV - 5);
    end

    // R8: write during the compensated second waits one interval
    for (int s = 0; s < INTERVAL - 1; s++) run_sec(len, c);
    ofs_i = 8'd7;
    run_sec(len, c);
    check(len == DIV - 5 && c, "R8 late write held", len, DIV - 5);
    check_ivl(DIV - 7, "R8 late write next interval");

    // R2: idle cycles do not advance
    for (int k = 0; k < 50; k++) begin
      @(negedge clk_i);
      if (sec_o) check(1'b0, "R2 idle no pulse", 1, 0);
    end
    check(sec_o == 1'b0, "R2 idle no pulse", int'(sec_o), 0);
    run_sec(len, c);
    check(len == DIV && !c, "R2 second after idle", len, DIV);

    // R9: clear mid-interval together with a tick
    for (int k = 0; k < 5; k++) do_tick(c, c);
    @(negedge clk_i) begin clr_i = 1'b1; osc_tick_i = 1'b1; end
    @(negedge clk_i) begin clr_i = 1'b0; osc_tick_i = 1'b0; end
    check(sec_o == 1'b0 && comp_o == 1'b0, "R9 clear outputs", int'({sec_o, comp_o}), 0);
    ofs_i = 8'd4;
    check_ivl(DIV - 4, "R9 interval restart");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule